// File: doc/BRIEF.md
# Dual Serial-Memory Controller Port Multiplexer

This block connects two octal serial-memory controllers to two external memory ports. A control register picks one of four routings. In the two one-to-one routings each controller owns a port, either straight or crossed. In the two shared routings both controllers take turns on one chosen port, and the other port is parked idle.

In a shared routing an arbiter hands the port to one controller per transaction. It alternates between the two when both are waiting. It holds the grant until the owner's chip selects have been asserted and then all released. It then keeps the port idle for a programmable number of cycles before the next grant. A chip-select override can fold a controller's chip-select activity onto one chosen line.

A second register splits a shared memory-mapped window. The upper part goes to the second controller in 64 MiB units, and the rest goes to the first. An address decoder steers each access to its owner and returns the offset inside that owner's region. Configuration writes are accepted only while both controllers are quiet.

Top module: `dual_mem_port_mux`

## Requirements
- R1: After reset the control word and the split word both read 0, and routing is straight (controller i on port i).
- R2: With cfg_sel=0 the control word reads back routing mode in bits [1:0], override enable in bit 4, override line in bits [6:5] and gap count in bits [23:16]; all other bits read 0. With cfg_sel=1 the split size reads back in bits [7:0].
- R3: Mode 0 drives port i from controller i, and mode 2 drives port i from controller 1-i. In both, chip selects, clock, data out and output enable pass through, each controller receives its own port's input data, and ctl_ack equals ctl_req.
- R4: In mode 1 (shared port 0) and mode 3 (shared port 1), the other port holds all chip selects high (inactive), clock 0, data 0 and output enable 0.
- R5: In a shared mode at most one ack is high. A request seen while the port is free is acknowledged on the next clock edge. The owner's signals drive the shared port, and the non-owner receives input data 0.
- R6: A grant is held until the owner has asserted any chip select and then released all of them. The ack drops on the edge that samples that release.
- R7: After a release, a waiting request is acknowledged after exactly gap+1 cycles with ack low.
- R8: When both controllers request, the one not served last wins. After reset controller 0 wins first.
- R9: With the override enabled, the routed port's chip-select vector is all high except line sel, which is low whenever any of the source controller's chip selects is low.
- R10: For address A, boundary B = (WIN_UNITS - min(split, WIN_UNITS)) * 2^26. If A >= B then mm_to_second=1 and mm_local=A-B. Otherwise mm_to_second=0 and mm_local=A.
- R11: A configuration write is ignored unless the arbiter is idle and every chip select of both controllers is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects control word, 1 selects split word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected word |
| ctl_req | input | 2 | Per-controller transaction request |
| ctl_ack | output | 2 | Per-controller grant |
| ctl_cs_n | input | 2×NCS | Controller chip selects, active low |
| ctl_sclk | input | 2 | Controller serial clocks |
| ctl_dq_o | input | 2×DW | Controller output data |
| ctl_dq_oe | input | 2 | Controller output enables |
| ctl_dq_i | output | 2×DW | Input data returned to each controller |
| mem_cs_n | output | 2×NCS | Port chip selects, active low |
| mem_sclk | output | 2 | Port serial clocks |
| mem_dq_o | output | 2×DW | Port output data |
| mem_dq_oe | output | 2 | Port output enables |
| mem_dq_i | input | 2×DW | Port input data |
| mm_addr | input | AW | Memory-mapped window address |
| mm_to_second | output | 1 | 1 when the address belongs to the second controller |
| mm_local | output | AW | Offset within the owning region |

## Verification
The bench counts the ack-low cycles between two shared transactions. A gap counter that is off by one, or one that grants straight away, shows up as a wrong count. It has both controllers request at once, across several transactions. A fixed-priority arbiter would then starve controller 1, and a pointer that is never updated would repeat the same owner. The window table covers addresses on both sides of the boundary, a zero split, a full split and an oversized split. Clamping missing from the decoder, or a wrong comparison edge, would misroute those addresses. Writes attempted mid-transaction must leave the readback untouched, which catches configuration that is not gated.

// File: rtl/dmpm_pkg.sv
package dmpm_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_BUSY = 2'd1,
    ARB_GAP  = 2'd2
  } arb_state_e;

  typedef struct packed {
    logic [7:0] gap;
    logic [1:0] ovr_sel;
    logic       ovr_en;
    logic [1:0] mode;
  } ctrl_t;

  localparam int UNIT_LSB = 26;

  function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
    ctrl_t c;
    c.mode    = w[1:0];
    c.ovr_en  = w[4];
    c.ovr_sel = w[6:5];
    c.gap     = w[23:16];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w        = '0;
    w[1:0]   = c.mode;
    w[4]     = c.ovr_en;
    w[6:5]   = c.ovr_sel;
    w[23:16] = c.gap;
    return w;
  endfunction

  // mode bit 0 turns on sharing
  function automatic logic is_shared(input logic [1:0] mode);
    return mode[0];
  endfunction

  // in shared modes, mode bit 1 names the port in use
  function automatic logic shared_port(input logic [1:0] mode);
    return mode[1];
  endfunction

  // in one-to-one modes, mode bit 1 crosses the routing
  function automatic logic direct_source(input logic [1:0] mode, input logic port);
    return port ^ mode[1];
  endfunction

endpackage

// File: rtl/dmpm_regs.sv
module dmpm_regs
  import dmpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        cfg_idle,
  output ctrl_t       ctrl,
  output logic [7:0]  split,
  output logic [31:0] cfg_rdata,
  output logic        wr_accept
);

  assign wr_accept = cfg_we && cfg_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      split <= '0;
    end else if (wr_accept) begin
      if (!cfg_sel) ctrl  <= ctrl_from_word(cfg_wdata);
      else          split <= cfg_wdata[7:0];
    end
  end

  assign cfg_rdata = cfg_sel ? {24'd0, split} : ctrl_to_word(ctrl);

endmodule

// File: rtl/dmpm_arb.sv
module dmpm_arb
  import dmpm_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shared,
  input  logic [GAP_W-1:0] gap,
  input  logic [1:0]       req,
  input  logic [1:0]       cs_idle,
  output logic             busy,
  output logic             owner,
  output logic [1:0]       ack,
  output logic             arb_idle,
  output logic             grant_evt,
  output logic             release_evt
);

  arb_state_e       st_q;
  logic             own_q, last_q, seen_q;
  logic [GAP_W-1:0] cnt_q;
  logic             pick, window_open;

  // round robin: on a tie the controller not served last wins
  assign pick        = (req == 2'b11) ? ~last_q : req[1];
  assign window_open = (st_q == ARB_IDLE) || (st_q == ARB_GAP && cnt_q == '0);
  assign grant_evt   = shared && (|req) && window_open;
  assign release_evt = (st_q == ARB_BUSY) && seen_q && cs_idle[own_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ARB_IDLE;
      own_q  <= 1'b0;
      last_q <= 1'b1;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!shared) begin
      st_q   <= ARB_IDLE;
      seen_q <= 1'b0;
    end else if (grant_evt) begin
      st_q   <= ARB_BUSY;
      own_q  <= pick;
      seen_q <= 1'b0;
    end else begin
      case (st_q)
        ARB_BUSY: begin
          if (release_evt) begin
            st_q   <= ARB_GAP;
            cnt_q  <= gap;
            last_q <= own_q;
          end else if (!cs_idle[own_q]) begin
            seen_q <= 1'b1;
          end
        end
        ARB_GAP: begin
          if (cnt_q == '0) st_q  <= ARB_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ARB_IDLE;
      endcase
    end
  end

  assign busy     = (st_q == ARB_BUSY);
  assign owner    = own_q;
  assign arb_idle = (st_q == ARB_IDLE);

  for (genvar c = 0; c < 2; c++) begin : g_ack
    assign ack[c] = shared ? (busy && (own_q == 1'(c))) : req[c];
  end

endmodule

// File: rtl/dmpm_route.sv
module dmpm_route
  import dmpm_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NCS = 4
) (
  input  ctrl_t                  ctrl,
  input  logic                   busy,
  input  logic                   owner,
  input  logic [1:0][NCS-1:0]    ctl_cs_n,
  input  logic [1:0]             ctl_sclk,
  input  logic [1:0][DW-1:0]     ctl_dq_o,
  input  logic [1:0]             ctl_dq_oe,
  output logic [1:0][DW-1:0]     ctl_dq_i,
  output logic [1:0][NCS-1:0]    mem_cs_n,
  output logic [1:0]             mem_sclk,
  output logic [1:0][DW-1:0]     mem_dq_o,
  output logic [1:0]             mem_dq_oe,
  input  logic [1:0][DW-1:0]     mem_dq_i
);

  // fold any active select onto one chosen line when the override is on
  function automatic logic [NCS-1:0] cs_apply(input logic [NCS-1:0] cs,
                                              input logic en,
                                              input logic [1:0] sel);
    logic [NCS-1:0] r;
    if (!en) return cs;
    r = '1;
    for (int i = 0; i < NCS; i++)
      if (i == int'(sel)) r[i] = &cs;
    return r;
  endfunction

  logic shr, sp;
  assign shr = is_shared(ctrl.mode);
  assign sp  = shared_port(ctrl.mode);

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic src_ok, src;
    always_comb begin
      src_ok = shr ? (busy && (sp == 1'(p))) : 1'b1;
      src    = shr ? owner : direct_source(ctrl.mode, 1'(p));
      if (src_ok) begin
        mem_cs_n[p]  = cs_apply(ctl_cs_n[src], ctrl.ovr_en, ctrl.ovr_sel);
        mem_sclk[p]  = ctl_sclk[src];
        mem_dq_o[p]  = ctl_dq_o[src];
        mem_dq_oe[p] = ctl_dq_oe[src];
      end else begin
        mem_cs_n[p]  = '1;
        mem_sclk[p]  = 1'b0;
        mem_dq_o[p]  = '0;
        mem_dq_oe[p] = 1'b0;
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ret
    always_comb begin
      if (shr)
        ctl_dq_i[c] = (busy && (owner == 1'(c))) ? mem_dq_i[sp] : '0;
      else
        ctl_dq_i[c] = mem_dq_i[direct_source(ctrl.mode, 1'(c))];
    end
  end

endmodule

// File: rtl/dmpm_win.sv
module dmpm_win
  import dmpm_pkg::*;
#(
  parameter int AW        = 28,
  parameter int WIN_UNITS = 4
) (
  input  logic [AW-1:0] addr,
  input  logic [7:0]    split,
  output logic          to_second,
  output logic [AW-1:0] local_addr
);

  // first unit index that belongs to the second controller
  function automatic int unsigned base_units(input logic [7:0] s);
    int unsigned k;
    k = (int'(s) > WIN_UNITS) ? WIN_UNITS : int'(s);
    return WIN_UNITS - k;
  endfunction

  logic [AW:0] boundary;

  always_comb begin
    boundary   = (AW+1)'(base_units(split)) << UNIT_LSB;
    to_second  = {1'b0, addr} >= boundary;
    local_addr = to_second ? (addr - boundary[AW-1:0]) : addr;
  end

endmodule

// File: rtl/dual_mem_port_mux.sv
module dual_mem_port_mux
  import dmpm_pkg::*;
#(
  parameter int DW        = 8,
  parameter int NCS       = 4,
  parameter int AW        = 28,
  parameter int WIN_UNITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_sel,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic [1:0]          ctl_req,
  output logic [1:0]          ctl_ack,
  input  logic [1:0][NCS-1:0] ctl_cs_n,
  input  logic [1:0]          ctl_sclk,
  input  logic [1:0][DW-1:0]  ctl_dq_o,
  input  logic [1:0]          ctl_dq_oe,
  output logic [1:0][DW-1:0]  ctl_dq_i,
  output logic [1:0][NCS-1:0] mem_cs_n,
  output logic [1:0]          mem_sclk,
  output logic [1:0][DW-1:0]  mem_dq_o,
  output logic [1:0]          mem_dq_oe,
  input  logic [1:0][DW-1:0]  mem_dq_i,
  input  logic [AW-1:0]       mm_addr,
  output logic                mm_to_second,
  output logic [AW-1:0]       mm_local
);

  ctrl_t       ctrl;
  logic [7:0]  split;
  logic [31:0] ctrl_word;
  logic        wr_accept, cfg_idle;
  logic        busy, owner, arb_idle, grant_evt, release_evt;
  logic [1:0]  cs_idle;

  assign cs_idle[0] = &ctl_cs_n[0];
  assign cs_idle[1] = &ctl_cs_n[1];
  assign cfg_idle   = arb_idle && (&cs_idle);
  assign ctrl_word  = ctrl_to_word(ctrl);

  dmpm_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .cfg_idle,
    .ctrl, .split, .cfg_rdata, .wr_accept
  );

  dmpm_arb #(.GAP_W(8)) u_arb (
    .clk, .rst_n,
    .shared      (is_shared(ctrl.mode)),
    .gap         (ctrl.gap),
    .req         (ctl_req),
    .cs_idle,
    .busy, .owner,
    .ack         (ctl_ack),
    .arb_idle, .grant_evt, .release_evt
  );

  dmpm_route #(.DW(DW), .NCS(NCS)) u_route (
    .ctrl, .busy, .owner,
    .ctl_cs_n, .ctl_sclk, .ctl_dq_o, .ctl_dq_oe, .ctl_dq_i,
    .mem_cs_n, .mem_sclk, .mem_dq_o, .mem_dq_oe, .mem_dq_i
  );

  dmpm_win #(.AW(AW), .WIN_UNITS(WIN_UNITS)) u_win (
    .addr       (mm_addr),
    .split,
    .to_second  (mm_to_second),
    .local_addr (mm_local)
  );

endmodule

// File: rtl/dmpm_chk.sv
module dmpm_chk #(
  parameter int NCS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mode,
  input logic [7:0]          gap,
  input logic [1:0]          ctl_ack,
  input logic [1:0][NCS-1:0] mem_cs_n,
  input logic [1:0]          mem_sclk,
  input logic [1:0]          mem_dq_oe,
  input logic                grant_evt,
  input logic                release_evt,
  input logic                wr_accept,
  input logic                cfg_we,
  input logic                cfg_idle,
  input logic [31:0]         ctrl_word
);

  logic [8:0] since_q;
  logic       rel_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q    <= '0;
      rel_seen_q <= 1'b0;
    end else if (release_evt) begin
      since_q    <= '0;
      rel_seen_q <= 1'b1;
    end else begin
      if (wr_accept) rel_seen_q <= 1'b0;
      if (since_q != 9'h1FF) since_q <= since_q + 1'b1;
    end
  end

  // R5
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[0] |-> $onehot0(ctl_ack));

  // R4
  parked_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[0] |-> ((&mem_cs_n[~mode[1]]) && !mem_dq_oe[~mode[1]] && !mem_sclk[~mode[1]]));

  // R6
  release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> (ctl_ack == 2'b00));

  // R6
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && (|ctl_ack) && !release_evt) |=> $stable(ctl_ack));

  // R7
  gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_evt && rel_seen_q) |-> (since_q >= {1'b0, gap}));

  // R11
  cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_idle) |=> $stable(ctrl_word));

endmodule

bind dual_mem_port_mux dmpm_chk #(.NCS(NCS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (ctrl.mode),
  .gap         (ctrl.gap),
  .ctl_ack     (ctl_ack),
  .mem_cs_n    (mem_cs_n),
  .mem_sclk    (mem_sclk),
  .mem_dq_oe   (mem_dq_oe),
  .grant_evt   (grant_evt),
  .release_evt (release_evt),
  .wr_accept   (wr_accept),
  .cfg_we      (cfg_we),
  .cfg_idle    (cfg_idle),
  .ctrl_word   (ctrl_word)
);

// File: tb/dual_mem_port_mux_tb.sv
`timescale 1ns/1ps
module dual_mem_port_mux_tb;

  localparam int DW = 8, NCS = 4, AW = 28, WIN_UNITS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [1:0] ctl_req = '0, ctl_ack;
  logic [1:0][NCS-1:0] ctl_cs_n = '1, mem_cs_n;
  logic [1:0] ctl_sclk = '0, ctl_dq_oe = '0, mem_sclk, mem_dq_oe;
  logic [1:0][DW-1:0] ctl_dq_o = '0, ctl_dq_i, mem_dq_o, mem_dq_i = '0;
  logic [AW-1:0] mm_addr = '0, mm_local;
  logic mm_to_second;

  always #5 clk = ~clk;

  dual_mem_port_mux #(.DW(DW), .NCS(NCS), .AW(AW), .WIN_UNITS(WIN_UNITS)) u_dut (.*);

  int total = 0, fails = 0;
  bit done = 1'b0;

  // {split[7:0], addr[27:0], expect_second, expect_local[27:0]}
  localparam logic [64:0] WIN_TAB [0:6] = '{
    {8'd0, 28'h0FFFFFF, 1'b0, 28'h0FFFFFF},
    {8'd1, 28'hBFFFFFF, 1'b0, 28'hBFFFFFF},
    {8'd1, 28'hC000000, 1'b1, 28'h0000000},
    {8'd2, 28'h8000010, 1'b1, 28'h0000010},
    {8'd4, 28'h0000005, 1'b1, 28'h0000005},
    {8'd9, 28'h4000000, 1'b1, 28'h4000000},
    {8'd3, 28'h3FFFFFF, 1'b0, 28'h3FFFFFF}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input string tag, input logic sel, input logic [31:0] exp);
    cfg_sel = sel; #1;
    chk(tag, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic quiet();
    ctl_cs_n = '1; ctl_req = '0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    cfg_read("R1 ctrl", 1'b0, 32'h0);
    cfg_read("R1 split", 1'b1, 32'h0);
    ctl_dq_o = {8'h3C, 8'hA5}; #1;
    chk("R1 straight", 64'(mem_dq_o), 64'h3CA5);

    // R2 field layout
    cfg_write(1'b0, 32'hFFAB_FF7C);
    cfg_read("R2 ctrl fields", 1'b0, 32'h00AB_0070);
    cfg_write(1'b1, 32'h0000_01FF);
    cfg_read("R2 split field", 1'b1, 32'h0000_00FF);
    cfg_write(1'b0, 32'h0);

    // R3 straight
    ctl_cs_n = {4'b0111, 4'b1110}; ctl_sclk = 2'b01; ctl_dq_oe = 2'b01;
    mem_dq_i = {8'h22, 8'h11}; ctl_req = 2'b10; #1;
    chk("R3 mode0 cs", 64'(mem_cs_n), 64'h7E);
    chk("R3 mode0 sclk/oe", 64'({mem_sclk, mem_dq_oe}), 64'h5);
    chk("R3 mode0 dq_i", 64'(ctl_dq_i), 64'h2211);
    chk("R3 mode0 ack", 64'(ctl_ack), 64'h2);
    // R11 write ignored while a chip select is active
    cfg_write(1'b0, 32'h2);
    cfg_read("R11 direct busy", 1'b0, 32'h0);
    quiet();
    cfg_write(1'b0, 32'h2);
    ctl_cs_n = {4'b0111, 4'b1110}; #1;
    chk("R3 mode2 cs", 64'(mem_cs_n), 64'hE7);
    chk("R3 mode2 dq_o", 64'(mem_dq_o), 64'hA53C);
    chk("R3 mode2 dq_i", 64'(ctl_dq_i), 64'h1122);
    quiet();

    // R9 override, line 2 then line 3
    cfg_write(1'b0, 32'h50);
    ctl_cs_n = {4'b1111, 4'b1101}; #1;
    chk("R9 line2", 64'(mem_cs_n), 64'hFB);
    quiet();
    cfg_write(1'b0, 32'h70);
    ctl_cs_n = {4'b1111, 4'b1110}; #1;
    chk("R9 line3", 64'(mem_cs_n), 64'hF7);
    quiet();

    // R10 window split table
    for (int i = 0; i < 7; i++) begin
      cfg_write(1'b1, {24'd0, WIN_TAB[i][64:57]});
      mm_addr = WIN_TAB[i][56:29]; #1;
      chk($sformatf("R10 entry %0d owner", i), 64'(mm_to_second), 64'(WIN_TAB[i][28]));
      chk($sformatf("R10 entry %0d offset", i), 64'(mm_local), 64'(WIN_TAB[i][27:0]));
    end

    // shared port 0, gap field 3
    cfg_write(1'b0, 32'h0003_0001);
    ctl_sclk = 2'b11; ctl_dq_oe = 2'b11;
    ctl_req = 2'b11;
    tick();
    chk("R8 first winner", 64'(ctl_ack), 64'h1);
    chk("R5 owner drives port", 64'(mem_dq_o[0]), 64'hA5);
    chk("R5 non-owner data", 64'(ctl_dq_i), 64'h0011);
    chk("R4 parked port", 64'({mem_cs_n[1], mem_sclk[1], mem_dq_oe[1]}), 64'h3C);
    ctl_cs_n = {4'b1111, 4'b1110};
    cfg_write(1'b0, 32'h0);
    cfg_read("R11 shared busy", 1'b0, 32'h0003_0001);
    chk("R6 held", 64'(ctl_ack), 64'h1);
    ctl_cs_n = '1;
    tick();
    chk("R6 drop on release", 64'(ctl_ack), 64'h0);
    n = 1;
    for (int k = 0; k < 20; k++) begin
      tick();
      if (ctl_ack != 2'b00) break;
      n++;
    end
    chk("R7 gap of 4", 64'(n), 64'd4);
    chk("R8 alternate", 64'(ctl_ack), 64'h2);
    chk("R5 port from ctl1", 64'(mem_dq_o[0]), 64'h3C);
    ctl_cs_n = {4'b1110, 4'b1111}; tick();
    ctl_cs_n = '1; tick();
    chk("R6 second release", 64'(ctl_ack), 64'h0);
    repeat (4) tick();
    chk("R8 back to ctl0", 64'(ctl_ack), 64'h1);
    ctl_req = 2'b00;
    ctl_cs_n = {4'b1111, 4'b1110}; tick();
    ctl_cs_n = '1;
    repeat (8) tick();

    // shared port 1, gap field 0
    cfg_write(1'b0, 32'h0000_0003);
    ctl_req = 2'b10;
    tick();
    chk("R5 grant mode3", 64'(ctl_ack), 64'h2);
    chk("R5 port1 from ctl1", 64'(mem_dq_o[1]), 64'h3C);
    chk("R4 port0 parked", 64'({mem_cs_n[0], mem_sclk[0], mem_dq_oe[0]}), 64'h3C);
    repeat (3) tick();
    chk("R6 no select no release", 64'(ctl_ack), 64'h2);
    ctl_cs_n = {4'b0111, 4'b1111}; tick();
    ctl_cs_n = '1; tick();
    chk("R6 release mode3", 64'(ctl_ack), 64'h0);
    n = 1;
    for (int k = 0; k < 20; k++) begin
      tick();
      if (ctl_ack != 2'b00) break;
      n++;
    end
    chk("R7 gap of 1", 64'(n), 64'd1);

    done = 1'b1;
    report();
    $finish;
  end

endmodule